// File: doc/BRIEF.md
# DMA Page-Table Address Translator

This block turns a 32-bit address issued by a DMA device into a physical memory address by looking it up in a flat, single-level page table that lives in system memory. Software sets up two configuration words, the table base and the table size in bytes, through a small register port. Each translation request names a device address. The block splits it into a 4096-byte page number and an in-page offset, checks the page number against the table size, and fetches the matching 8-byte table entry through a memory read port. It then hands back the physical address with read/write permission, or address 0 with no permission when the page is outside the table or the fetch reports an error.

The translation request port is valid/ready. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must keep `req_valid` and `req_addr` steady until that edge. One translation is in flight at a time. The result appears as a one-cycle `res_valid` strobe with no back-pressure, so the consumer must take it in that cycle. The memory read request is also valid/ready, and the memory side may hold `mem_req_ready` low for as long as it needs. The memory response is a single-cycle `mem_rsp_valid` strobe that the block always accepts.

Top module: `ptx_translator`

## Requirements
- R1: After reset, the base and limit registers read back as 0, `req_ready` is 1 and `res_valid` is 0. A lookup made before software programs the registers returns no permission and issues no memory read.
- R2: The base register is at register offset 0x18 and the limit register is at offset 0x20. Each holds a full 32-bit write and reads back on `cfg_rdata` combinationally when `cfg_addr` selects it. Every other offset reads as 0.
- R3: A write to offset 0x28 (table invalidate), or to any other unmapped offset, changes neither register.
- R4: The page index is `req_addr[31:12]`. A table fetch happens only when the index is strictly less than `limit >> 3`. Otherwise no memory read is issued and the result is `res_addr` = 0 with `res_perm` = 2'b00 (none).
- R5: The entry fetch address is `{1'b0, base[30:0]} + index*8`, taken modulo 2^32.
- R6: The frame word is `mem_rsp_data[31:0]`, and the owner word `mem_rsp_data[63:32]` is ignored. On a fetch without error, `res_addr` = `{frame[31:12], req_addr[11:0]}` and `res_perm` = 2'b11 (read/write).
- R7: A response with `mem_rsp_err` = 1 gives `res_addr` = 0 and `res_perm` = 2'b00.
- R8: `req_ready` is low from the cycle after a request is accepted through the cycle in which `res_valid` is high. `res_valid` is high for exactly one cycle per accepted request.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the block keeps `mem_req_valid` high and `mem_req_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator idle, can accept a request |
| req_addr | input | 32 | Device-side address to translate |
| mem_req_valid | output | 1 | Table entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 64 | Entry: frame in [31:0], owner in [63:32] |
| mem_rsp_err | input | 1 | Read response reports a failure |
| res_valid | output | 1 | One-cycle result strobe |
| res_addr | output | 32 | Translated physical address |
| res_perm | output | 2 | 2'b11 read/write, 2'b00 none |

## Verification
The hardest case to reach from the ports is a table-entry read that stalls on the memory side, because the request address must stay frozen through the stall. The bench reaches it by letting its memory model pull `mem_req_ready` low on alternate cycles and delay its responses. A monitor checks every stalled cycle for a stable request. The other hard cases are the edges of the range check and of the address sum: an index one below and one at `limit >> 3`, a limit that is not a multiple of 8, a base with bit 31 set, and an entry address that crosses the 2^31 boundary. These come from a vector table that reprograms base and limit before each lookup. A forced error response covers the failed fetch.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RW   = 2'b11
  } perm_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/ptx_cfg_regs.sv
module ptx_cfg_regs #(
  parameter int ADDR_W    = 32,
  parameter int CFG_AW    = 8,
  parameter int BASE_OFS  = 'h18,
  parameter int LIMIT_OFS = 'h20,
  parameter int INVAL_OFS = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] limit_q
);
  localparam logic [CFG_AW-1:0] BASE_A  = BASE_OFS[CFG_AW-1:0];
  localparam logic [CFG_AW-1:0] LIMIT_A = LIMIT_OFS[CFG_AW-1:0];
  localparam logic [CFG_AW-1:0] INVAL_A = INVAL_OFS[CFG_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == BASE_A)  base_q  <= cfg_wdata;
      if (cfg_addr == LIMIT_A) limit_q <= cfg_wdata;
    end
  end

  always_comb begin
    if (cfg_addr == BASE_A)       cfg_rdata = base_q;
    else if (cfg_addr == LIMIT_A) cfg_rdata = limit_q;
    else                          cfg_rdata = '0;
  end

  AST_INVAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == INVAL_A) |=> ($stable(base_q) && $stable(limit_q))); // R3
endmodule

// File: rtl/ptx_range.sv
module ptx_range #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BITS  = 12,
  parameter int ENTRY_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic [ADDR_W-1:0] vaddr,
  output logic              in_range,
  output logic [ADDR_W-1:0] entry_addr
);
  logic [ADDR_W-1:0] page_idx;
  logic [ADDR_W-1:0] n_entries;
  logic [ADDR_W-1:0] base_m;

  assign page_idx   = vaddr >> PAGE_BITS;
  assign n_entries  = limit >> ENTRY_LOG2;
  assign in_range   = page_idx < n_entries;
  assign base_m     = {1'b0, base[ADDR_W-2:0]};
  assign entry_addr = base_m + (page_idx << ENTRY_LOG2);

  AST_SMALL_LIMIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (limit < (ADDR_W'(1) << ENTRY_LOG2)) |-> !in_range); // R4
  AST_TOP_BASE_BIT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (vaddr < (ADDR_W'(1) << PAGE_BITS)) |-> (entry_addr[ADDR_W-1] == 1'b0)); // R5
endmodule

// File: rtl/ptx_walk.sv
module ptx_walk
  import ptx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              in_range,
  input  logic [ADDR_W-1:0] entry_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_frame,
  input  logic              mem_rsp_err,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_addr,
  output logic [1:0]        res_perm
);
  walk_st_e             st;
  logic [PAGE_BITS-1:0] off_q;
  logic [ADDR_W-1:0]    ea_q;
  logic [ADDR_W-1:0]    res_addr_q;
  perm_e                perm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      off_q      <= '0;
      ea_q       <= '0;
      res_addr_q <= '0;
      perm_q     <= PERM_NONE;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          off_q <= req_addr[PAGE_BITS-1:0];
          ea_q  <= entry_addr;
          if (in_range) begin
            st <= ST_FETCH;
          end else begin
            res_addr_q <= '0;
            perm_q     <= PERM_NONE;
            st         <= ST_DONE;
          end
        end
        ST_FETCH: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            res_addr_q <= '0;
            perm_q     <= PERM_NONE;
          end else begin
            res_addr_q <= {mem_frame[ADDR_W-1:PAGE_BITS], off_q};
            perm_q     <= PERM_RW;
          end
          st <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_FETCH);
  assign mem_req_addr  = ea_q;
  assign res_valid     = (st == ST_DONE);
  assign res_addr      = res_addr_q;
  assign res_perm      = perm_q;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R8
  AST_BUSY_WHILE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready); // R8
  AST_OOR_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !in_range) |=> (res_valid && !mem_req_valid && res_perm == PERM_NONE)); // R4
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9
  AST_ERR_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && mem_rsp_valid && mem_rsp_err) |=> (res_valid && res_perm == PERM_NONE && res_addr == '0)); // R7
endmodule

// File: rtl/ptx_translator.sv
module ptx_translator #(
  parameter int ADDR_W     = 32,
  parameter int CFG_AW     = 8,
  parameter int PAGE_BITS  = 12,
  parameter int ENTRY_LOG2 = 3,
  parameter int BASE_OFS   = 'h18,
  parameter int LIMIT_OFS  = 'h20,
  parameter int INVAL_OFS  = 'h28
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [ADDR_W-1:0]   cfg_wdata,
  output logic [ADDR_W-1:0]   cfg_rdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [ADDR_W-1:0]   mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [2*ADDR_W-1:0] mem_rsp_data,
  input  logic                mem_rsp_err,
  output logic                res_valid,
  output logic [ADDR_W-1:0]   res_addr,
  output logic [1:0]          res_perm
);
  logic [ADDR_W-1:0] base_q, limit_q, entry_addr;
  logic              in_range;
  logic              unused_owner;

  assign unused_owner = ^mem_rsp_data[2*ADDR_W-1:ADDR_W];

  ptx_cfg_regs #(
    .ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .BASE_OFS(BASE_OFS),
    .LIMIT_OFS(LIMIT_OFS), .INVAL_OFS(INVAL_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .base_q(base_q), .limit_q(limit_q)
  );

  ptx_range #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENTRY_LOG2(ENTRY_LOG2)
  ) u_range (
    .clk(clk), .rst_n(rst_n), .base(base_q), .limit(limit_q),
    .vaddr(req_addr), .in_range(in_range), .entry_addr(entry_addr)
  );

  ptx_walk #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)
  ) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .in_range(in_range), .entry_addr(entry_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_frame(mem_rsp_data[ADDR_W-1:0]), .mem_rsp_err(mem_rsp_err),
    .res_valid(res_valid), .res_addr(res_addr), .res_perm(res_perm)
  );
endmodule

// File: tb/ptx_translator_bench.sv
module ptx_translator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        res_valid;
  logic [31:0] res_addr;
  logic [1:0]  res_perm;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // memory model state
  logic        stall_en = 1'b0;
  int          lat_cfg = 2;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  int          pend_cnt = 0;
  int          hs_cnt = 0;
  logic [31:0] last_ea = '0;
  int          hold_viol = 0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;

  ptx_translator u_ptx_translator (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .res_valid(res_valid), .res_addr(res_addr), .res_perm(res_perm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] frame_of(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_A5A5;
  endfunction

  // memory model: valid/ready request, delayed single-cycle response
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_req_ready <= stall_en ? ~mem_req_ready : 1'b1;
    if (mem_req_valid && mem_req_ready && !pend) begin
      pend      <= 1'b1;
      pend_addr <= mem_req_addr;
      pend_cnt  <= lat_cfg;
      hs_cnt    <= hs_cnt + 1;
      last_ea   <= mem_req_addr;
    end else if (pend) begin
      if (pend_cnt == 0) begin
        pend          <= 1'b0;
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= {~frame_of(pend_addr), frame_of(pend_addr)};
        mem_rsp_err   <= err_en && (pend_addr == err_addr);
      end else begin
        pend_cnt <= pend_cnt - 1;
      end
    end
  end

  // R9 monitor: a stalled request must stay up with the same address
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr))
        hold_viol <= hold_viol + 1;
      prev_stall <= mem_req_valid && !mem_req_ready;
      prev_addr  <= mem_req_addr;
    end
  end

  initial begin
    wait (cycles >= WATCHDOG);
    fails = fails + 1;
    tests = tests + 1;
    $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  // issue one translation; reports busy-ready violations and strobe length
  task automatic xlate(input logic [31:0] a, output logic [31:0] ra,
                       output logic [1:0] rp, output int busy_bad, output int strobe_len);
    int n;
    busy_bad = 0; strobe_len = 0; ra = '0; rp = 2'b01;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!res_valid && n < 200) begin
      if (req_ready) busy_bad++;
      @(negedge clk);
      n++;
    end
    if (res_valid) begin
      if (req_ready) busy_bad++;
      ra = res_addr; rp = res_perm;
    end
    while (res_valid) begin
      strobe_len++;
      @(negedge clk);
    end
  endtask

  // {base, limit, addr, force_error}
  localparam logic [96:0] VEC [0:7] = '{
    {32'h0000_1000, 32'h0000_0100, 32'h0000_5ABC, 1'b0},
    {32'h8000_2000, 32'h0000_0040, 32'h0000_7123, 1'b0},
    {32'h8000_2000, 32'h0000_0040, 32'h0000_8123, 1'b0},
    {32'h0010_0000, 32'h0000_0047, 32'h0000_7FFF, 1'b0},
    {32'h0010_0000, 32'h0000_0047, 32'h0000_8000, 1'b0},
    {32'h0000_1000, 32'h0000_1000, 32'h0012_3456, 1'b1},
    {32'h7FFF_FFF8, 32'hFFFF_FFFF, 32'h0000_2FFF, 1'b0},
    {32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_F001, 1'b0}
  };

  initial begin
    logic [31:0] rd, ra, exp_a, ea, b, l, a;
    logic [1:0]  rp, exp_p;
    logic        inr, ef;
    int bb, sl, h0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    cfg_read(8'h18, rd); check32("R1 base after reset", rd, 32'h0);
    cfg_read(8'h20, rd); check32("R1 limit after reset", rd, 32'h0);
    check32("R1 req_ready after reset", {31'h0, req_ready}, 32'h1);
    check32("R1 res_valid after reset", {31'h0, res_valid}, 32'h0);
    h0 = hs_cnt;
    xlate(32'h0000_0123, ra, rp, bb, sl);
    check32("R1 unprogrammed perm none", {30'h0, rp}, 32'h0);
    check32("R1 unprogrammed no fetch", hs_cnt - h0, 32'h0);

    // R2: map and readback
    cfg_write(8'h18, 32'hDEAD_BEEF);
    cfg_write(8'h20, 32'h1234_5678);
    cfg_read(8'h18, rd); check32("R2 base readback", rd, 32'hDEAD_BEEF);
    cfg_read(8'h20, rd); check32("R2 limit readback", rd, 32'h1234_5678);
    cfg_read(8'h30, rd); check32("R2 unmapped reads 0", rd, 32'h0);

    // R3: invalidate and unmapped writes ignored
    cfg_write(8'h28, 32'hFFFF_FFFF);
    cfg_write(8'h1C, 32'h0BAD_0BAD);
    cfg_read(8'h18, rd); check32("R3 base unchanged", rd, 32'hDEAD_BEEF);
    cfg_read(8'h20, rd); check32("R3 limit unchanged", rd, 32'h1234_5678);

    // R4 R5 R6 R7: vector walk, with back-pressure on odd vectors
    for (int i = 0; i < 8; i++) begin
      {b, l, a, ef} = VEC[i];
      stall_en = i[0];
      lat_cfg  = (i % 3);
      cfg_write(8'h18, b);
      cfg_write(8'h20, l);
      inr = (a >> 12) < (l >> 3);
      ea  = {1'b0, b[30:0]} + ((a >> 12) << 3);
      err_en = ef; err_addr = ea;
      if (!inr || ef) begin exp_a = 32'h0; exp_p = 2'b00; end
      else begin exp_a = {frame_of(ea)[31:12], a[11:0]}; exp_p = 2'b11; end
      h0 = hs_cnt;
      xlate(a, ra, rp, bb, sl);
      check32($sformatf("R6 R7 vec%0d addr", i), ra, exp_a);
      check32($sformatf("R4 R6 vec%0d perm", i), {30'h0, rp}, {30'h0, exp_p});
      check32($sformatf("R4 vec%0d fetch count", i), hs_cnt - h0, inr ? 32'h1 : 32'h0);
      if (inr) check32($sformatf("R5 vec%0d entry addr", i), last_ea, ea);
      check32($sformatf("R8 vec%0d ready low while busy", i), bb, 32'h0);
      check32($sformatf("R8 vec%0d strobe length", i), sl, 32'h1);
    end
    err_en = 1'b0;

    // R9: long stall with slow memory
    stall_en = 1'b1; lat_cfg = 4;
    cfg_write(8'h18, 32'h0000_4000);
    cfg_write(8'h20, 32'h0000_0800);
    xlate(32'h0000_3210, ra, rp, bb, sl);
    check32("R6 stalled fetch addr", ra, {frame_of(32'h0000_4018)[31:12], 12'h210});
    check32("R9 request held while stalled", hold_viol, 32'h0);
    stall_en = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule